// File: doc/BRIEF.md
# Command-Driven Burst Bus Master

This block is a bus master meant to sit in front of a memory controller and exercise it. It takes a stream of commands, each an opcode with a 32-bit operand, over a valid/ready handshake. Some commands only load internal settings: the base address, the base data word, the burst length, the beat at which a stall is inserted, and the length of that stall. The rest launch single or burst reads and writes on a simple strobe-and-ready bus.

Each beat of a transaction derives its address and data from the loaded bases and the beat index. Writes put the pattern on the bus. Reads can compare the returned word against the same pattern. When a read word does not match, the block reports the address, the word it received and the word it expected, and it adds one to an error counter that saturates. Each transaction ends with a one-cycle done pulse and a pass flag. A controller under test can therefore be driven with a short, readable command list and no hand-written bus vectors.

Top module: `burst_master`

## Requirements
- R1: Opcodes 1 (base address), 2 (base data), 4 (read checking on/off, operand bit 0), 6 (burst length), 7 (stall beat) and 8 (stall length) only load a setting from the operand. They cause no read or write strobe, and `cmd_ready_o` stays high.
- R2: Opcode 3 (single write) and opcode 5 (single read) make exactly one beat at the base address, with `bus_last_o` high. A single write drives the base data word.
- R3: Opcodes 9 (burst write) and 10 (burst read) make N beats, where N is the loaded burst length and a length of 0 is treated as 1. Beat i (counting from 0) uses address base+i and data base_data XOR i. `bus_last_o` is high on the final beat only.
- R4: When the stall beat P is nonzero and the stall length L is nonzero, L cycles with both strobes low come just before beat P (counting from 1) of every transaction. With P = 0 or L = 0, no stall cycles are inserted.
- R5: While a strobe is high and `bus_ready_i` is low, the beat is held: the strobe, address and data stay unchanged until the slave accepts.
- R6: With checking on, every read beat is compared with base_data XOR i. A mismatch raises `mis_valid_o` for one cycle, in the cycle after the beat, carrying the beat address, the received word and the expected word.
- R7: With checking off, read data is never flagged, and `pass_o` reads 1 at the end of the transaction.
- R8: `done_o` pulses for exactly one cycle, in the cycle after the final beat is accepted. `pass_o` is valid in that cycle and is 0 only if a mismatch occurred in that transaction. With a slave that is always ready, done appears N+L cycles after the accepting clock edge.
- R9: Commands are taken only while the block is idle. `cmd_ready_o` is low from the edge that accepts a transaction opcode until the cycle in which `done_o` is high.
- R10: The error counter is 0 after reset, adds one for each mismatch, and holds at its maximum value.
- R11: Opcodes 0 and 11 to 15 are accepted and have no effect on the bus or on any setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block idle, command taken |
| cmd_op_i | input | 4 | Opcode |
| cmd_arg_i | input | 32 | Operand |
| bus_addr_o | output | 16 | Beat word address |
| bus_wdata_o | output | 32 | Beat write data |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_last_o | output | 1 | Final beat marker |
| bus_ready_i | input | 1 | Slave accepts current beat |
| bus_rdata_i | input | 32 | Read data, valid with ready |
| done_o | output | 1 | Transaction finished pulse |
| pass_o | output | 1 | Last transaction had no mismatch |
| mis_valid_o | output | 1 | Mismatch report pulse |
| mis_addr_o | output | 16 | Address of mismatching beat |
| mis_got_o | output | 32 | Received word |
| mis_exp_o | output | 32 | Expected word |
| err_count_o | output | 4 | Saturating mismatch count |

## Verification
A command is taken at the rising edge where valid and ready are both high. The bench drives commands at falling edges and reads results at the following falling edges. With a slave that is always ready, the first beat is on the bus in the cycle after acceptance, `done_o` is seen exactly N+L falling edges after acceptance, and `mis_valid_o` appears in that same done cycle for a mismatch on the last beat. The bus monitor counts beats only in cycles where the strobe and ready are both high. It counts stall cycles as busy cycles with no strobe, and it records the beat count at the first stall. After a transaction, the bench waits one more falling edge before it reads the monitor totals, so it never races the monitor at the done edge.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam logic [3:0] OP_SET_ADDR  = 4'd1;
  localparam logic [3:0] OP_SET_DATA  = 4'd2;
  localparam logic [3:0] OP_WR_ONE    = 4'd3;
  localparam logic [3:0] OP_CHK       = 4'd4;
  localparam logic [3:0] OP_RD_ONE    = 4'd5;
  localparam logic [3:0] OP_SET_BEATS = 4'd6;
  localparam logic [3:0] OP_STALL_AT  = 4'd7;
  localparam logic [3:0] OP_STALL_LEN = 4'd8;
  localparam logic [3:0] OP_WR_BURST  = 4'd9;
  localparam logic [3:0] OP_RD_BURST  = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BEAT} bm_state_e;
endpackage

// File: rtl/bm_cfg.sv
module bm_cfg #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] arg_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [BW-1:0] beats_o,
  output logic [BW-1:0] stall_at_o,
  output logic [BW-1:0] stall_len_o,
  output logic          chk_o
);
  import bm_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o      <= '0;
      data_o      <= '0;
      beats_o     <= BW'(1);
      stall_at_o  <= '0;
      stall_len_o <= '0;
      chk_o       <= 1'b0;
    end else if (we_i) begin
      case (op_i)
        OP_SET_ADDR:  addr_o      <= arg_i[AW-1:0];
        OP_SET_DATA:  data_o      <= arg_i;
        OP_SET_BEATS: beats_o     <= arg_i[BW-1:0];
        OP_STALL_AT:  stall_at_o  <= arg_i[BW-1:0];
        OP_STALL_LEN: stall_len_o <= arg_i[BW-1:0];
        OP_CHK:       chk_o       <= arg_i[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bm_seq.sv
module bm_seq #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          start_rd_i,
  input  logic          start_burst_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [DW-1:0] base_data_i,
  input  logic [BW-1:0] beats_i,
  input  logic [BW-1:0] stall_at_i,
  input  logic [BW-1:0] stall_len_i,
  input  logic          bus_ready_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic          bus_last_o,
  output logic          fire_o,
  output logic          busy_o,
  output logic          done_o
);
  import bm_pkg::*;

  bm_state_e     state_q;
  logic [BW-1:0] beat_q, last_q, wcnt_q;
  logic          rd_q;
  logic          strobe;
  logic [BW:0]   next_pos;

  assign strobe      = (state_q == S_BEAT);
  assign bus_rd_o    = strobe & rd_q;
  assign bus_wr_o    = strobe & ~rd_q;
  assign bus_last_o  = strobe & (beat_q == last_q);
  assign bus_addr_o  = base_addr_i + AW'(beat_q);
  assign bus_wdata_o = base_data_i ^ DW'(beat_q);
  assign fire_o      = strobe & bus_ready_i;
  assign busy_o      = (state_q != S_IDLE);
  // 1-based position of the beat that follows the current one
  assign next_pos    = {1'b0, beat_q} + (BW+1)'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      last_q  <= '0;
      wcnt_q  <= '0;
      rd_q    <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          rd_q   <= start_rd_i;
          beat_q <= '0;
          last_q <= (start_burst_i && beats_i != '0) ? beats_i - BW'(1) : '0;
          if (stall_at_i == BW'(1) && stall_len_i != '0) begin
            state_q <= S_WAIT;
            wcnt_q  <= stall_len_i;
          end else begin
            state_q <= S_BEAT;
          end
        end
        S_WAIT: begin
          if (wcnt_q == BW'(1)) state_q <= S_BEAT;
          else                  wcnt_q  <= wcnt_q - BW'(1);
        end
        S_BEAT: if (bus_ready_i) begin
          if (beat_q == last_q) begin
            state_q <= S_IDLE;
            done_o  <= 1'b1;
          end else begin
            beat_q <= beat_q + BW'(1);
            if (next_pos == {1'b0, stall_at_i} && stall_len_i != '0) begin
              state_q <= S_WAIT;
              wcnt_q  <= stall_len_i;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_hold_on_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !bus_ready_i) |=> (strobe && $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_rd_o)));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/bm_chk.sv
module bm_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int EW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          fire_i,
  input  logic          rd_i,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] exp_i,
  output logic          mis_valid_o,
  output logic [AW-1:0] mis_addr_o,
  output logic [DW-1:0] mis_got_o,
  output logic [DW-1:0] mis_exp_o,
  output logic [EW-1:0] err_o,
  output logic          pass_o
);
  localparam logic [EW-1:0] ERR_MAX = '1;

  logic mism;
  assign mism = fire_i & rd_i & en_i & (rdata_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mis_valid_o <= 1'b0;
      mis_addr_o  <= '0;
      mis_got_o   <= '0;
      mis_exp_o   <= '0;
      err_o       <= '0;
      pass_o      <= 1'b0;
    end else begin
      mis_valid_o <= mism;
      if (mism) begin
        mis_addr_o <= addr_i;
        mis_got_o  <= rdata_i;
        mis_exp_o  <= exp_i;
        if (err_o != ERR_MAX) err_o <= err_o + EW'(1);
      end
      if (start_i)   pass_o <= 1'b1;
      else if (mism) pass_o <= 1'b0;
    end
  end

  assert_mis_differs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_valid_o |-> (mis_got_o != mis_exp_o));

  assert_err_hold_max_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o == ERR_MAX) |=> (err_o == ERR_MAX));

  assert_err_monotone_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (err_o >= $past(err_o)));
endmodule

// File: rtl/burst_master.sv
module burst_master #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BW = 8,
  parameter int EW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [3:0]    cmd_op_i,
  input  logic [DW-1:0] cmd_arg_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic          bus_last_o,
  input  logic          bus_ready_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          mis_valid_o,
  output logic [AW-1:0] mis_addr_o,
  output logic [DW-1:0] mis_got_o,
  output logic [DW-1:0] mis_exp_o,
  output logic [EW-1:0] err_count_o
);
  import bm_pkg::*;

  logic          accept, busy, fire, start, start_rd, start_burst;
  logic [AW-1:0] base_addr;
  logic [DW-1:0] base_data;
  logic [BW-1:0] beats, stall_at, stall_len;
  logic          chk_en;

  assign cmd_ready_o = ~busy;
  assign accept      = cmd_valid_i & cmd_ready_o;
  assign start_rd    = (cmd_op_i == OP_RD_ONE)   || (cmd_op_i == OP_RD_BURST);
  assign start_burst = (cmd_op_i == OP_WR_BURST) || (cmd_op_i == OP_RD_BURST);
  assign start       = accept & (start_rd || start_burst || cmd_op_i == OP_WR_ONE);

  bm_cfg #(.AW(AW), .DW(DW), .BW(BW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(accept), .op_i(cmd_op_i), .arg_i(cmd_arg_i),
    .addr_o(base_addr), .data_o(base_data), .beats_o(beats),
    .stall_at_o(stall_at), .stall_len_o(stall_len), .chk_o(chk_en)
  );

  bm_seq #(.AW(AW), .DW(DW), .BW(BW)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .start_rd_i(start_rd), .start_burst_i(start_burst),
    .base_addr_i(base_addr), .base_data_i(base_data), .beats_i(beats),
    .stall_at_i(stall_at), .stall_len_i(stall_len),
    .bus_ready_i,
    .bus_addr_o, .bus_wdata_o, .bus_rd_o, .bus_wr_o, .bus_last_o,
    .fire_o(fire), .busy_o(busy), .done_o
  );

  // expected read word equals the pattern driven on the write data lines
  bm_chk #(.AW(AW), .DW(DW), .EW(EW)) u_chk (
    .clk_i, .rst_ni,
    .start_i(start), .fire_i(fire), .rd_i(bus_rd_o), .en_i(chk_en),
    .addr_i(bus_addr_o), .rdata_i(bus_rdata_i), .exp_i(bus_wdata_o),
    .mis_valid_o, .mis_addr_o, .mis_got_o, .mis_exp_o,
    .err_o(err_count_o), .pass_o
  );

  assert_busy_blocks_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) |-> !cmd_ready_o);

  assert_last_in_beat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_last_o |-> (bus_rd_o || bus_wr_o));

  assert_idle_no_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !(bus_rd_o || bus_wr_o));
endmodule

// File: tb/burst_master_tb.sv
module burst_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [31:0] cmd_arg = '0;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rd, bus_wr, bus_last, bus_ready;
  logic        done, pass, mis_valid;
  logic [15:0] mis_addr;
  logic [31:0] mis_got, mis_exp;
  logic [3:0]  err_count;

  logic [31:0] mem [0:63] = '{default: '0};
  logic [31:0] corrupt = '0;
  logic        slow = 1'b0;
  logic        tog = 1'b0;

  int tests = 0;
  int fails = 0;

  // monitor state
  int act_cnt = 0;
  int t_beats = 0, t_gap = 0, t_gap_before = -1, t_last_cnt = 0, t_last_at = 0, t_mis = 0;
  logic [15:0] t_mis_addr = '0;
  logic [31:0] t_mis_got = '0, t_mis_exp = '0;
  logic prev_ready = 1'b1;

  always #10 clk = ~clk;

  assign bus_ready = slow ? tog : 1'b1;
  assign bus_rdata = mem[bus_addr[5:0]] ^ corrupt;

  always @(posedge clk) tog <= ~tog;

  burst_master u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_arg_i(cmd_arg),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_last_o(bus_last),
    .bus_ready_i(bus_ready), .bus_rdata_i(bus_rdata),
    .done_o(done), .pass_o(pass),
    .mis_valid_o(mis_valid), .mis_addr_o(mis_addr),
    .mis_got_o(mis_got), .mis_exp_o(mis_exp),
    .err_count_o(err_count)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ready && !cmd_ready) begin
        t_beats = 0; t_gap = 0; t_gap_before = -1;
        t_last_cnt = 0; t_last_at = 0; t_mis = 0;
      end
      if (bus_rd || bus_wr) act_cnt++;
      if ((bus_rd || bus_wr) && bus_ready) begin
        t_beats++;
        if (bus_wr) mem[bus_addr[5:0]] = bus_wdata;
        if (bus_last) begin t_last_cnt++; t_last_at = t_beats; end
      end
      if (!cmd_ready && !bus_rd && !bus_wr) begin
        if (t_gap == 0) t_gap_before = t_beats;
        t_gap++;
      end
      if (mis_valid) begin
        t_mis++; t_mis_addr = mis_addr; t_mis_got = mis_got; t_mis_exp = mis_exp;
      end
      prev_ready = cmd_ready;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [31:0] arg);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // launch a transaction, wait for done, then step past it
  task automatic run(input logic [3:0] op, output int lat, output logic pass_at_done);
    send(op, '0);
    chk(!cmd_ready, "R9 ready low after start", 32'(cmd_ready), 0);
    lat = 0;
    while (!done) begin @(negedge clk); lat++; end
    pass_at_done = pass;
    chk(cmd_ready, "R9 ready high at done", 32'(cmd_ready), 1);
    @(negedge clk);
    chk(!done, "R8 done is one cycle", 32'(done), 0);
    #1;
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R9 reset ready", 32'(cmd_ready), 1);
    chk(!bus_rd && !bus_wr, "R1 reset strobes", {30'd0, bus_rd, bus_wr}, 0);
    chk(!done && !mis_valid, "R8 reset done", {30'd0, done, mis_valid}, 0);
    chk(err_count == '0, "R10 reset err count", 32'(err_count), 0);
  endtask

  task automatic t_loads_quiet();
    int a0;
    a0 = act_cnt;
    send(4'd1, 32'h0000_0010);
    send(4'd2, 32'hA5A5_0000);
    send(4'd7, 32'd0);
    send(4'd8, 32'd0);
    send(4'd6, 32'd1);
    chk(cmd_ready, "R1 ready stays high", 32'(cmd_ready), 1);
    // R11: undefined opcodes with operands that would move the settings
    send(4'd0, 32'h0000_0033);
    send(4'd11, 32'h0000_0033);
    send(4'd15, 32'h0000_0033);
    @(negedge clk); #1;
    chk(act_cnt == a0, "R1 R11 no bus activity", act_cnt, a0);
  endtask

  task automatic t_single();
    int lat; logic p;
    run(4'd3, lat, p);
    chk(t_beats == 1, "R2 single write beats", t_beats, 1);
    chk(mem[16] == 32'hA5A5_0000, "R2 R11 single write data at base", mem[16], 32'hA5A5_0000);
    chk(t_last_cnt == 1, "R2 last on single", t_last_cnt, 1);
    chk(lat == 1, "R8 single latency", lat, 1);
    send(4'd4, 32'd1);
    run(4'd5, lat, p);
    chk(p == 1'b1 && t_mis == 0, "R6 single read passes", {31'd0, p}, 1);
    chk(t_beats == 1, "R2 single read beats", t_beats, 1);
  endtask

  task automatic t_burst();
    int lat; logic p;
    send(4'd6, 32'd5);
    send(4'd1, 32'h0000_0020);
    send(4'd2, 32'h1234_5670);
    run(4'd9, lat, p);
    chk(t_beats == 5, "R3 burst write beats", t_beats, 5);
    chk(lat == 5, "R8 burst latency", lat, 5);
    chk(t_last_cnt == 1 && t_last_at == 5, "R3 last on final only", t_last_at, 5);
    for (int i = 0; i < 5; i++)
      chk(mem[32+i] == (32'h1234_5670 ^ 32'(i)), "R3 burst pattern", mem[32+i], 32'h1234_5670 ^ 32'(i));
    run(4'd10, lat, p);
    chk(p && t_mis == 0 && t_beats == 5, "R6 burst read passes", t_mis, 0);
    // length 0 acts as 1
    send(4'd6, 32'd0);
    send(4'd1, 32'h0000_0030);
    run(4'd9, lat, p);
    chk(t_beats == 1, "R3 zero length gives one beat", t_beats, 1);
    chk(mem[48] == 32'h1234_5670, "R3 zero length data", mem[48], 32'h1234_5670);
  endtask

  task automatic t_stall();
    int lat; logic p;
    send(4'd6, 32'd4);
    send(4'd1, 32'h0000_0020);
    send(4'd7, 32'd3);
    send(4'd8, 32'd2);
    run(4'd10, lat, p);
    chk(t_gap == 2, "R4 stall length", t_gap, 2);
    chk(t_gap_before == 2, "R4 stall before beat 3", t_gap_before, 2);
    chk(lat == 6, "R8 latency with stall", lat, 6);
    chk(p, "R4 stalled read passes", {31'd0, p}, 1);
    send(4'd7, 32'd0);
    run(4'd10, lat, p);
    chk(t_gap == 0 && lat == 4, "R4 position zero disables", t_gap, 0);
    send(4'd7, 32'd1);
    send(4'd8, 32'd3);
    run(4'd5, lat, p);
    chk(t_gap == 3 && t_gap_before == 0, "R4 stall on first beat", t_gap, 3);
    send(4'd8, 32'd0);
    run(4'd5, lat, p);
    chk(t_gap == 0, "R4 length zero disables", t_gap, 0);
    send(4'd7, 32'd0);
  endtask

  task automatic t_slow();
    int lat; logic p;
    slow = 1'b1;
    send(4'd6, 32'd4);
    send(4'd1, 32'h0000_0038);
    send(4'd2, 32'h0F0F_0000);
    run(4'd9, lat, p);
    chk(t_beats == 4 && lat > 4, "R5 stretched burst beats", t_beats, 4);
    for (int i = 0; i < 4; i++)
      chk(mem[56+i] == (32'h0F0F_0000 ^ 32'(i)), "R5 stretched write data", mem[56+i], 32'h0F0F_0000 ^ 32'(i));
    run(4'd10, lat, p);
    chk(p && t_mis == 0, "R5 stretched read passes", t_mis, 0);
    slow = 1'b0;
  endtask

  task automatic t_mismatch();
    int lat; logic p;
    send(4'd1, 32'h0000_0010);
    send(4'd2, 32'hA5A5_0000);
    corrupt = 32'h0000_0100;
    run(4'd5, lat, p);
    chk(t_mis == 1, "R6 one mismatch report", t_mis, 1);
    chk(t_mis_addr == 16'h0010, "R6 mismatch address", 32'(t_mis_addr), 32'h10);
    chk(t_mis_got == 32'hA5A5_0100, "R6 mismatch got", t_mis_got, 32'hA5A5_0100);
    chk(t_mis_exp == 32'hA5A5_0000, "R6 mismatch expected", t_mis_exp, 32'hA5A5_0000);
    chk(!p, "R8 pass low on mismatch", {31'd0, p}, 0);
    chk(err_count == 4'd1, "R10 count one", 32'(err_count), 1);
    send(4'd4, 32'd0);
    send(4'd6, 32'd3);
    run(4'd10, lat, p);
    chk(t_mis == 0 && p, "R7 check off no report", t_mis, 0);
    chk(err_count == 4'd1, "R7 count unchanged", 32'(err_count), 1);
    send(4'd4, 32'd1);
    send(4'd6, 32'd20);
    send(4'd1, 32'h0000_0000);
    send(4'd2, 32'hCAFE_0000);
    run(4'd10, lat, p);
    chk(t_mis == 20 && lat == 20, "R6 every beat reported", t_mis, 20);
    chk(err_count == 4'hF, "R10 count saturates", 32'(err_count), 32'hF);
    corrupt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_loads_quiet();
    t_single();
    t_burst();
    t_stall();
    t_slow();
    t_mismatch();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end
endmodule